// File: doc/BRIEF.md
# Flash Bank Access Conflict Controller

This block stands between one bus slave port and a small set of flash banks. It settles what happens when a bus access meets a bank that is running a program or erase command. Each bank carries a busy flag for as long as its command runs. A loadable down-counter per bank sets how long that is. When the command ends, the result lands in a flop-based array model and the flag drops in the same clock step.

A read that targets a busy bank is handled in one of two ways, chosen by `stall_en`. It either ends at once with an error response, or it is held off by keeping `req_ready` low until the bank goes idle. A read to an idle bank always completes with array data, even while other banks are busy. Every accepted bus write starts a program command in the bank it addresses. Two command interpreters own the banks: a normal one and a security one. The last bank is a data region owned by the security interpreter. Every other bank, including the second-to-last data region, is owned by the normal interpreter. A write is refused while the interpreter that owns its region is busy. An erase port lets either interpreter start an erase on any bank.

The request channel is valid/ready: a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and inputs must be held until then. Back-pressure happens only for a read to a busy bank with `stall_en` set. The response channel has no ready: `rsp_valid` pulses for one cycle, one cycle after each accepted request, and the receiver must take it.

Top module: `flash_cc`

## Requirements
- R1: Address map. `req_addr[6]`=1 selects the status word. Otherwise `req_addr[5:4]` is the bank and `req_addr[3:0]` is the word. Bank 3 is the security-owned data region, bank 2 is the normal-owned data region, and banks 0 and 1 are normal-owned program banks. The status word holds bank busy flags in bits 3:0, the normal interpreter busy flag in bit 4, the security interpreter busy flag in bit 5, and zeros above.
- R2: A read to an idle bank is accepted in the cycle it is presented. One cycle later `rsp_valid`=1 and `rsp_err`=0, with the word's data on `rsp_rdata`, even while another bank is busy.
- R3: With `stall_en`=0, a read to a busy bank is accepted at once. Its response has `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0, and lasts exactly one cycle.
- R4: With `stall_en`=1, `req_ready` stays low for a read to a busy bank while the bank is busy. The read is accepted in the first cycle the bank is idle, and its response has no error and carries the newly programmed data.
- R5: An accepted write to an idle bank whose owner is idle gets a response with no error. It starts a program command that keeps the bank busy for exactly `prog_cycles` cycles, a value of 0 acting as 1. The written word is readable once busy clears.
- R6: A write is answered with an error, and starts nothing, if its bank is busy or if the normal interpreter is busy and the bank is one that interpreter owns.
- R7: A write to bank 3 is answered with an error while the security interpreter is busy. The security interpreter's busy state does not block writes to normal-owned banks.
- R8: An erase request (`erase_valid`, bank, owner, cycle count) starts only if the bank is idle, its owner is idle and no bus write is accepted in that cycle; otherwise it is dropped. The bank stays busy for `erase_cycles` cycles, then every word of the bank reads as all ones.
- R9: Status reads are never held off, even with `stall_en`=1 and banks busy. Writes to the status address are answered with an error.
- R10: Writes are never held off: `req_ready` is high for any write.
- R11: After reset, no bank or interpreter is busy, every array word reads all ones, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_en | input | 1 | 1: hold off reads to busy banks; 0: answer them with an error |
| prog_cycles | input | 8 | Duration of a program command started by a bus write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Request address (see R1) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data (zero on errors and writes) |
| erase_valid | input | 1 | Erase request strobe |
| erase_bank | input | 2 | Bank to erase |
| erase_secure | input | 1 | 1 = security interpreter issues the erase |
| erase_cycles | input | 8 | Duration of the erase |

## Verification
The bench counts how long a read stays held off against a busy bank. It also counts how many back-to-back status polls show a bank busy. A design whose counter runs one cycle long or short, or that releases a stalled read before the array has been updated, gives a wrong count or returns stale data. The bench drives the two interpreters against each other: a security erase in a program bank must block writes into the security region while writes into the normal region go through. A design that shares one busy flag, or that keys on the bank rather than the owner, fails one side of this. The bench also issues an erase that collides with a running one. If the design starts it anyway, the bank goes busy again after the first erase ends.

// File: rtl/flash_cc_pkg.sv
package flash_cc_pkg;

  // Which command interpreter owns a running command or a region.
  typedef enum logic {
    OWNER_NORMAL = 1'b0,
    OWNER_SECURE = 1'b1
  } owner_e;

  // How an incoming bus request is answered.
  typedef enum logic [1:0] {
    ACT_OK    = 2'd0,
    ACT_ERR   = 2'd1,
    ACT_STALL = 2'd2
  } act_e;

endpackage

// File: rtl/flash_cc_timer.sv
module flash_cc_timer
  import flash_cc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WORD_W = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cycles,
  input  owner_e            load_owner,
  input  logic              load_erase,
  input  logic [WORD_W-1:0] load_word,
  input  logic [DW-1:0]     load_data,
  output logic              busy,
  output owner_e            owner,
  output logic              done,
  output logic              pend_erase,
  output logic [WORD_W-1:0] pend_word,
  output logic [DW-1:0]     pend_data
);

  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      owner      <= OWNER_NORMAL;
      pend_erase <= 1'b0;
      pend_word  <= '0;
      pend_data  <= '0;
    end else if (load) begin
      cnt        <= (load_cycles == '0) ? CNT_W'(1) : load_cycles;
      owner      <= load_owner;
      pend_erase <= load_erase;
      pend_word  <= load_word;
      pend_data  <= load_data;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R5: a launched command makes the bank busy on the next cycle
  p_load_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R7: the owner of a running command does not change under it
  p_owner_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> $stable(owner));

endmodule

// File: rtl/flash_cc_array.sv
module flash_cc_array #(
  parameter int NB     = 4,
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  parameter int BANK_W = 2,
  parameter int WORD_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NB-1:0]               wr_done,
  input  logic [NB-1:0]               wr_erase,
  input  logic [NB-1:0][WORD_W-1:0]   wr_word,
  input  logic [NB-1:0][DW-1:0]       wr_data,
  input  logic [BANK_W-1:0]           rd_bank,
  input  logic [WORD_W-1:0]           rd_word,
  output logic [DW-1:0]               rd_data
);

  localparam int CELLS = NB * WORDS;

  logic [DW-1:0] cell_q [CELLS];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DW-1:0] val;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val <= '1;
        end else if (wr_done[b]) begin
          if (wr_erase[b])                      val <= '1;
          else if (wr_word[b] == WORD_W'(w))    val <= wr_data[b];
        end
      end
      assign cell_q[b*WORDS + w] = val;
    end
  end

  assign rd_data = cell_q[{rd_bank, rd_word}];

endmodule

// File: rtl/flash_cc_decide.sv
module flash_cc_decide
  import flash_cc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2
) (
  input  logic              is_status,
  input  logic              is_write,
  input  logic [BANK_W-1:0] bank,
  input  logic [NB-1:0]     bank_busy,
  input  logic              nrm_busy,
  input  logic              sec_busy,
  input  logic              stall_en,
  output act_e              act,
  output owner_e            region_owner
);

  logic owner_busy;

  always_comb begin
    region_owner = (bank == BANK_W'(NB-1)) ? OWNER_SECURE : OWNER_NORMAL;
    owner_busy   = (region_owner == OWNER_SECURE) ? sec_busy : nrm_busy;
    if (is_status)
      act = is_write ? ACT_ERR : ACT_OK;
    else if (is_write)
      act = (bank_busy[bank] || owner_busy) ? ACT_ERR : ACT_OK;
    else if (bank_busy[bank])
      act = stall_en ? ACT_STALL : ACT_ERR;
    else
      act = ACT_OK;
  end

endmodule

// File: rtl/flash_cc.sv
module flash_cc
  import flash_cc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  parameter int CNT_W  = 8,
  localparam int BANK_W = $clog2(NB),
  localparam int WORD_W = $clog2(WORDS),
  localparam int AW     = 1 + BANK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_en,
  input  logic [CNT_W-1:0]  prog_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              erase_valid,
  input  logic [BANK_W-1:0] erase_bank,
  input  logic              erase_secure,
  input  logic [CNT_W-1:0]  erase_cycles
);

  // ---------------- request decode
  logic              is_status;
  logic [BANK_W-1:0] bank;
  logic [WORD_W-1:0] word;

  assign is_status = req_addr[AW-1];
  assign bank      = req_addr[AW-2 -: BANK_W];
  assign word      = req_addr[WORD_W-1:0];

  // ---------------- per-bank state
  logic [NB-1:0]             bank_busy;
  logic [NB-1:0]             bank_done;
  logic [NB-1:0]             pend_erase;
  logic [NB-1:0][WORD_W-1:0] pend_word;
  logic [NB-1:0][DW-1:0]     pend_data;
  owner_e                    bank_owner [NB];
  logic                      nrm_busy;
  logic                      sec_busy;

  always_comb begin
    nrm_busy = 1'b0;
    sec_busy = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (bank_busy[b]) begin
        if (bank_owner[b] == OWNER_SECURE) sec_busy = 1'b1;
        else                               nrm_busy = 1'b1;
      end
    end
  end

  // ---------------- conflict decision
  act_e   act;
  owner_e region_owner;

  flash_cc_decide #(
    .NB     (NB),
    .BANK_W (BANK_W)
  ) u_decide (
    .is_status    (is_status),
    .is_write     (req_write),
    .bank         (bank),
    .bank_busy    (bank_busy),
    .nrm_busy     (nrm_busy),
    .sec_busy     (sec_busy),
    .stall_en     (stall_en),
    .act          (act),
    .region_owner (region_owner)
  );

  logic hs;
  logic wr_go;
  logic erase_go;
  logic erase_owner_busy;

  assign req_ready        = (act != ACT_STALL);
  assign hs               = req_valid && req_ready;
  assign wr_go            = hs && req_write && (act == ACT_OK) && !is_status;
  assign erase_owner_busy = erase_secure ? sec_busy : nrm_busy;
  assign erase_go         = erase_valid && !(hs && req_write) &&
                            !bank_busy[erase_bank] && !erase_owner_busy;

  // ---------------- command timers, one per bank
  for (genvar b = 0; b < NB; b++) begin : g_timer
    logic   wr_here;
    logic   er_here;
    owner_e ld_owner;

    assign wr_here  = wr_go && (bank == BANK_W'(b));
    assign er_here  = erase_go && (erase_bank == BANK_W'(b));
    assign ld_owner = wr_here ? region_owner
                              : (erase_secure ? OWNER_SECURE : OWNER_NORMAL);

    flash_cc_timer #(
      .CNT_W  (CNT_W),
      .WORD_W (WORD_W),
      .DW     (DW)
    ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (wr_here || er_here),
      .load_cycles (wr_here ? prog_cycles : erase_cycles),
      .load_owner  (ld_owner),
      .load_erase  (!wr_here),
      .load_word   (word),
      .load_data   (req_wdata),
      .busy        (bank_busy[b]),
      .owner       (bank_owner[b]),
      .done        (bank_done[b]),
      .pend_erase  (pend_erase[b]),
      .pend_word   (pend_word[b]),
      .pend_data   (pend_data[b])
    );
  end

  // ---------------- array model
  logic [DW-1:0] rd_data;

  flash_cc_array #(
    .NB     (NB),
    .WORDS  (WORDS),
    .DW     (DW),
    .BANK_W (BANK_W),
    .WORD_W (WORD_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_done  (bank_done),
    .wr_erase (pend_erase),
    .wr_word  (pend_word),
    .wr_data  (pend_data),
    .rd_bank  (bank),
    .rd_word  (word),
    .rd_data  (rd_data)
  );

  // ---------------- status word
  logic [DW-1:0] status_word;

  always_comb begin
    status_word         = '0;
    status_word[NB-1:0] = bank_busy;
    status_word[NB]     = nrm_busy;
    status_word[NB+1]   = sec_busy;
  end

  // ---------------- response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= hs;
      rsp_err   <= hs && (act == ACT_ERR);
      if (hs && !req_write && (act == ACT_OK))
        rsp_rdata <= is_status ? status_word : rd_data;
      else
        rsp_rdata <= '0;
    end
  end

  // ---------------- assertions
  // R3: an error response carries no data
  p_err_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  // R3: errors only appear as part of a response
  p_err_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R10: writes are never held off
  p_write_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> req_ready);

  // R9: status accesses are never held off
  p_status_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[AW-1]) |-> req_ready);

  // R4: holding off a request happens only with the stall policy chosen
  p_stall_needs_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> stall_en);

  // R2: every accepted request yields a response on the next cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

endmodule

// File: tb/tb_flash_cc.sv
module tb_flash_cc;

  localparam logic [6:0] STATUS = 7'h40;
  localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_en = 1'b0;
  logic [7:0]  prog_cycles = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        erase_valid = 1'b0;
  logic [1:0]  erase_bank = '0;
  logic        erase_secure = 1'b0;
  logic [7:0]  erase_cycles = 8'd1;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  flash_cc dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_en     (stall_en),
    .prog_cycles  (prog_cycles),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .erase_valid  (erase_valid),
    .erase_bank   (erase_bank),
    .erase_secure (erase_secure),
    .erase_cycles (erase_cycles)
  );

  always #10ns clk = ~clk;

  function automatic logic [6:0] fa(input int b, input int w);
    return {1'b0, 2'(b), 4'(w)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_read(input logic [6:0] a, output logic e, output logic [31:0] d,
                          output int waits);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; waits = 0;
    #1ns;
    while (!req_ready) begin
      @(negedge clk); #1ns; waits++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid after read", 32'(rsp_valid), 32'd1);
    e = rsp_err; d = rsp_rdata;
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d, input int cyc,
                           output logic e);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    prog_cycles = 8'(cyc);
    #1ns;
    chk("R10 write ready", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R5 rsp_valid after write", 32'(rsp_valid), 32'd1);
    e = rsp_err;
  endtask

  task automatic erase(input int b, input bit sec, input int cyc);
    erase_valid = 1'b1; erase_bank = 2'(b); erase_secure = sec; erase_cycles = 8'(cyc);
    @(negedge clk);
    erase_valid = 1'b0;
  endtask

  // Back-to-back status reads; returns how many showed the bit set.
  task automatic poll_busy(input int bit_idx, output int n);
    logic e; logic [31:0] d; int w;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      bus_read(STATUS, e, d, w);
      if (!d[bit_idx]) break;
      n++;
    end
  endtask

  task automatic t_reset();
    logic e; logic [31:0] d; int w;
    chk("R11 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
    bus_read(STATUS, e, d, w);
    chk("R11 status idle", d, 32'd0);
    bus_read(fa(1, 5), e, d, w);
    chk("R11 array erased", d, ONES);
    chk("R11 no error", 32'(e), 32'd0);
  endtask

  task automatic t_idle_read();
    logic e; logic [31:0] d; int w, n;
    stall_en = 1'b1;
    bus_write(fa(1, 2), 32'hA5A5_0001, 3, e);
    chk("R5 write ok", 32'(e), 32'd0);
    poll_busy(1, n);
    chk("R5 program duration", 32'(n), 32'd3);
    bus_read(fa(1, 2), e, d, w);
    chk("R5 programmed data", d, 32'hA5A5_0001);
    bus_write(fa(0, 0), 32'h0000_0B0B, 20, e);
    bus_read(fa(1, 2), e, d, w);
    chk("R2 idle bank no wait", 32'(w), 32'd0);
    chk("R2 idle bank data", d, 32'hA5A5_0001);
    chk("R2 idle bank no error", 32'(e), 32'd0);
    poll_busy(0, n);
    bus_read(fa(0, 0), e, d, w);
    chk("R1 bank 0 word 0 data", d, 32'h0000_0B0B);
  endtask

  task automatic t_err_read();
    logic e; logic [31:0] d; int w, n;
    stall_en = 1'b0;
    bus_write(fa(0, 1), 32'h0000_1111, 6, e);
    bus_read(fa(0, 1), e, d, w);
    chk("R3 no wait", 32'(w), 32'd0);
    chk("R3 error flag", 32'(e), 32'd1);
    chk("R3 data zero", d, 32'd0);
    @(negedge clk);
    chk("R3 one-cycle response", 32'(rsp_valid), 32'd0);
    poll_busy(0, n);
    bus_read(fa(0, 1), e, d, w);
    chk("R3 data after busy", d, 32'h0000_1111);
  endtask

  task automatic t_stall_read();
    logic e; logic [31:0] d; int w;
    stall_en = 1'b1;
    bus_write(fa(1, 3), 32'h0000_CAFE, 6, e);
    bus_read(fa(1, 3), e, d, w);
    chk("R4 held-off cycles", 32'(w), 32'd6);
    chk("R4 no error", 32'(e), 32'd0);
    chk("R4 new data", d, 32'h0000_CAFE);
  endtask

  task automatic t_status_and_df_normal();
    logic e; logic [31:0] d; int w, n;
    stall_en = 1'b1;
    bus_write(fa(2, 0), 32'h0000_0022, 8, e);
    chk("R5 df normal write ok", 32'(e), 32'd0);
    bus_read(STATUS, e, d, w);
    chk("R9 status no wait", 32'(w), 32'd0);
    chk("R1 status bank2 + normal", d, 32'h0000_0014);
    bus_write(STATUS, 32'h1, 1, e);
    chk("R9 status write error", 32'(e), 32'd1);
    bus_write(fa(2, 1), 32'h0000_0033, 3, e);
    chk("R6 df normal busy error", 32'(e), 32'd1);
    bus_write(fa(0, 4), 32'h0000_0044, 3, e);
    chk("R6 normal-owned bank error", 32'(e), 32'd1);
    poll_busy(2, n);
    bus_read(STATUS, e, d, w);
    chk("R6 nothing started", d, 32'd0);
    bus_read(fa(2, 1), e, d, w);
    chk("R6 refused word untouched", d, ONES);
    bus_read(fa(0, 4), e, d, w);
    chk("R6 refused pf word untouched", d, ONES);
    bus_read(fa(2, 0), e, d, w);
    chk("R6 accepted word", d, 32'h0000_0022);
  endtask

  task automatic t_df_secure();
    logic e; logic [31:0] d; int w, n;
    erase(0, 1'b1, 10);
    bus_read(STATUS, e, d, w);
    chk("R7 status bank0 + secure", d, 32'h0000_0021);
    erase(0, 1'b0, 3);
    bus_write(fa(3, 0), 32'h0000_0044, 4, e);
    chk("R7 df secure busy error", 32'(e), 32'd1);
    bus_write(fa(2, 2), 32'h0000_0055, 2, e);
    chk("R7 df normal unaffected", 32'(e), 32'd0);
    poll_busy(0, n);
    @(negedge clk); @(negedge clk);
    bus_read(STATUS, e, d, w);
    chk("R8 colliding erase dropped", d, 32'd0);
    bus_read(fa(0, 1), e, d, w);
    chk("R8 bank 0 erased", d, ONES);
    bus_read(fa(2, 2), e, d, w);
    chk("R7 df normal data", d, 32'h0000_0055);
    bus_read(fa(3, 0), e, d, w);
    chk("R7 refused secure word untouched", d, ONES);
    bus_write(fa(3, 0), 32'h0000_0044, 4, e);
    chk("R7 df secure write ok", 32'(e), 32'd0);
    bus_read(STATUS, e, d, w);
    chk("R7 secure owner of bank3", d, 32'h0000_0028);
    poll_busy(3, n);
    bus_read(fa(3, 0), e, d, w);
    chk("R7 df secure data", d, 32'h0000_0044);
  endtask

  task automatic t_erase_len();
    logic e; logic [31:0] d; int w, n;
    erase(1, 1'b0, 4);
    poll_busy(1, n);
    chk("R8 erase duration", 32'(n), 32'd4);
    bus_read(fa(1, 3), e, d, w);
    chk("R8 bank 1 erased", d, ONES);
  endtask

  task automatic t_zero_cycles();
    logic e; int n;
    bus_write(fa(1, 0), 32'h0000_0007, 0, e);
    poll_busy(1, n);
    chk("R5 zero acts as one", 32'(n), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_read();
    t_err_read();
    t_stall_read();
    t_status_and_df_normal();
    t_df_secure();
    t_erase_len();
    t_zero_cycles();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule